// File: doc/BRIEF.md
# Hole-Aware Line Access Redirector

This block sits in a memory controller between the cache hierarchy and memory. It serves cache-miss reads and line writebacks for pages that may have been duplicated lazily: a duplicated page can carry holes, which are lines that were never physically copied and still live in another page. For every request the block reads the page's metadata line and checks the minor counter kept for the addressed line. A counter of zero marks a hole. The page number of the source is held one bit at a time in the metadata slots.

A read of a hole is sent on to the same line of the source page. If that page has a hole there as well, the walk goes on from page to page until a page that holds the line is found. A write to a hole first fetches the line from the page found by the walk. It then merges the request's enabled bytes over that line, writes the full line to the addressed page, and rewrites that page's metadata so the hole is closed. The number of redirections is capped, so a broken or circular chain ends with an error response.

Top module: `hole_redirect`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` and `mem_valid` are 0. No memory request is issued while the block is idle.
- R2: A read of a present line (minor counter nonzero) issues one metadata read (`mem_meta`=1) for the addressed page, then one data read of that page and line. It returns that data with `rsp_err`=0.
- R3: Metadata slot i occupies bits [4i+3:4i]. Bits [4i+2:4i] hold line i's minor counter, and bit 4i+3 is bit i of the source page number. A zero minor counter makes the access move to the same line of the source page. Lines that are present in the page are read from the page itself.
- R4: Redirection repeats while the line is also a hole in the source page. Each page visited costs exactly one metadata read, and the data comes from the first page that holds the line.
- R5: At most 8 redirections are made per request. A request that would need a 9th one, including one on a circular chain, ends with `rsp_err`=1 and `rsp_data`=0, and no memory write is made.
- R6: A write to a present line of the addressed page is a single data write to that page and line, carrying the request's byte enables. No metadata write is made.
- R7: A write to a hole reads the line from the page that holds it. Byte k of the result comes from the request when `req_be[k]`=1 and from the fetched line otherwise. The full line is written to the addressed page. The page's metadata is then rewritten with that line's minor counter set to 1, while its pointer bit and every other slot stay unchanged. The source line is not modified.
- R8: Requests are served one at a time: `req_ready` falls in the cycle after a request is accepted and rises again with the response. Each response is a one-cycle `rsp_valid` pulse carrying the request's tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_we | input | 1 | 1 = writeback, 0 = read |
| req_page | input | 16 | Page number |
| req_line | input | 4 | Line index within the page |
| req_wdata | input | 64 | Write data |
| req_be | input | 8 | Byte enables for the write |
| req_tag | input | 4 | Request tag |
| rsp_valid | output | 1 | Response pulse |
| rsp_tag | output | 4 | Tag of the request being answered |
| rsp_data | output | 64 | Read data (0 for writes and errors) |
| rsp_err | output | 1 | Redirection limit exceeded |
| mem_valid | output | 1 | Memory request present |
| mem_ready | input | 1 | Memory accepts the request |
| mem_we | output | 1 | Memory write |
| mem_meta | output | 1 | Access targets the page's metadata line |
| mem_page | output | 16 | Memory page number |
| mem_line | output | 4 | Memory line index (0 for metadata) |
| mem_wdata | output | 64 | Memory write data |
| mem_be | output | 8 | Memory byte enables |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 64 | Returned data or metadata line |

## Verification
The hardest condition to reach from the ports is the redirection limit. It needs a chain of nine linked pages whose holes line up on the same line, plus a chain that points back to itself. The bench writes such metadata straight into its memory model, using page links that count up one step at a time. It then requests the chain from one page in, which needs exactly 8 redirections, and from the chain's head, which needs 9. This puts both sides of the limit next to each other. A write to a hole is then read back through the block, to confirm that the closed hole no longer sends the access on.

// File: rtl/hole_redirect_pkg.sv
package hole_redirect_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_META,
    S_DATA,
    S_WFILL,
    S_WLAST
  } walk_state_t;
endpackage

// File: rtl/meta_lookup.sv
module meta_lookup #(
  parameter int LINES = 16,
  parameter int CNT_W = 3,
  localparam int SLOT_W = CNT_W + 1,
  localparam int META_W = LINES * SLOT_W,
  localparam int LIDX_W = $clog2(LINES)
) (
  input  logic [META_W-1:0] meta,
  input  logic [LIDX_W-1:0] line,
  output logic [CNT_W-1:0]  minor,
  output logic [LINES-1:0]  src_page
);
  logic [SLOT_W-1:0] slots [LINES];

  for (genvar i = 0; i < LINES; i++) begin : g_slot
    assign slots[i]    = meta[i*SLOT_W +: SLOT_W];
    assign src_page[i] = slots[i][SLOT_W-1];
  end

  assign minor = slots[line][CNT_W-1:0];
endmodule

// File: rtl/meta_close.sv
module meta_close #(
  parameter int LINES = 16,
  parameter int CNT_W = 3,
  localparam int SLOT_W = CNT_W + 1,
  localparam int META_W = LINES * SLOT_W,
  localparam int LIDX_W = $clog2(LINES)
) (
  input  logic [META_W-1:0] meta_in,
  input  logic [LIDX_W-1:0] line,
  output logic [META_W-1:0] meta_out
);
  for (genvar i = 0; i < LINES; i++) begin : g_slot
    always_comb begin
      meta_out[i*SLOT_W +: SLOT_W] = meta_in[i*SLOT_W +: SLOT_W];
      if (line == LIDX_W'(i))
        meta_out[i*SLOT_W +: CNT_W] = CNT_W'(1);
    end
  end
endmodule

// File: rtl/byte_merge.sv
module byte_merge #(
  parameter int DATA_W = 64,
  localparam int BE_W = DATA_W / 8
) (
  input  logic [DATA_W-1:0] old_line,
  input  logic [DATA_W-1:0] new_line,
  input  logic [BE_W-1:0]   be,
  output logic [DATA_W-1:0] merged
);
  for (genvar k = 0; k < BE_W; k++) begin : g_byte
    assign merged[k*8 +: 8] = be[k] ? new_line[k*8 +: 8] : old_line[k*8 +: 8];
  end
endmodule

// File: rtl/hole_redirect.sv
module hole_redirect
  import hole_redirect_pkg::*;
#(
  parameter int LINES    = 16,
  parameter int CNT_W    = 3,
  parameter int MAX_HOPS = 8,
  parameter int TAG_W    = 4,
  localparam int PAGE_W  = LINES,
  localparam int LIDX_W  = $clog2(LINES),
  localparam int DATA_W  = LINES * (CNT_W + 1),
  localparam int BE_W    = DATA_W / 8,
  localparam int HOP_W   = $clog2(MAX_HOPS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [PAGE_W-1:0] req_page,
  input  logic [LIDX_W-1:0] req_line,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [BE_W-1:0]   req_be,
  input  logic [TAG_W-1:0]  req_tag,
  output logic              rsp_valid,
  output logic [TAG_W-1:0]  rsp_tag,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_err,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic              mem_meta,
  output logic [PAGE_W-1:0] mem_page,
  output logic [LIDX_W-1:0] mem_line,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [BE_W-1:0]   mem_be,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata
);
  walk_state_t       st;
  logic              r_we, first;
  logic [PAGE_W-1:0] r_page, cur_page;
  logic [LIDX_W-1:0] r_line;
  logic [DATA_W-1:0] r_wdata, dest_meta;
  logic [BE_W-1:0]   r_be;
  logic [TAG_W-1:0]  r_tag;
  logic [HOP_W-1:0]  hops;

  logic [CNT_W-1:0]  minor;
  logic [PAGE_W-1:0] src_page;
  logic [DATA_W-1:0] closed_meta, merged;
  logic              present, hop_limit;

  meta_lookup #(.LINES(LINES), .CNT_W(CNT_W)) lookup_i (
    .meta(mem_rdata), .line(r_line), .minor(minor), .src_page(src_page));

  meta_close #(.LINES(LINES), .CNT_W(CNT_W)) close_i (
    .meta_in(dest_meta), .line(r_line), .meta_out(closed_meta));

  byte_merge #(.DATA_W(DATA_W)) merge_i (
    .old_line(mem_rdata), .new_line(r_wdata), .be(r_be), .merged(merged));

  assign present   = (minor != '0);
  assign hop_limit = (hops == HOP_W'(MAX_HOPS));

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE;
      req_ready <= 1'b1;
      rsp_valid <= 1'b0;
      rsp_tag <= '0;
      rsp_data <= '0;
      rsp_err <= 1'b0;
      mem_valid <= 1'b0;
      mem_we <= 1'b0;
      mem_meta <= 1'b0;
      mem_page <= '0;
      mem_line <= '0;
      mem_wdata <= '0;
      mem_be <= '0;
      r_we <= 1'b0;
      first <= 1'b0;
      r_page <= '0;
      cur_page <= '0;
      r_line <= '0;
      r_wdata <= '0;
      dest_meta <= '0;
      r_be <= '0;
      r_tag <= '0;
      hops <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (mem_valid && mem_ready) mem_valid <= 1'b0;
      case (st)
        S_IDLE: begin
          if (req_valid) begin
            r_we <= req_we;
            r_page <= req_page;
            r_line <= req_line;
            r_wdata <= req_wdata;
            r_be <= req_be;
            r_tag <= req_tag;
            cur_page <= req_page;
            hops <= '0;
            first <= 1'b1;
            req_ready <= 1'b0;
            mem_valid <= 1'b1;
            mem_we <= 1'b0;
            mem_meta <= 1'b1;
            mem_page <= req_page;
            mem_line <= '0;
            mem_wdata <= '0;
            mem_be <= '1;
            st <= S_META;
          end
        end
        S_META: begin
          if (mem_rvalid) begin
            first <= 1'b0;
            if (first) dest_meta <= mem_rdata;
            if (present) begin
              mem_valid <= 1'b1;
              mem_meta <= 1'b0;
              mem_page <= cur_page;
              mem_line <= r_line;
              if (r_we && first) begin
                mem_we <= 1'b1;
                mem_wdata <= r_wdata;
                mem_be <= r_be;
                st <= S_WLAST;
              end else begin
                mem_we <= 1'b0;
                st <= S_DATA;
              end
            end else if (hop_limit) begin
              rsp_valid <= 1'b1;
              rsp_err <= 1'b1;
              rsp_data <= '0;
              rsp_tag <= r_tag;
              req_ready <= 1'b1;
              st <= S_IDLE;
            end else begin
              hops <= hops + 1'b1;
              cur_page <= src_page;
              mem_valid <= 1'b1;
              mem_we <= 1'b0;
              mem_meta <= 1'b1;
              mem_page <= src_page;
              mem_line <= '0;
            end
          end
        end
        S_DATA: begin
          if (mem_rvalid) begin
            if (r_we) begin
              mem_valid <= 1'b1;
              mem_we <= 1'b1;
              mem_meta <= 1'b0;
              mem_page <= r_page;
              mem_line <= r_line;
              mem_wdata <= merged;
              mem_be <= '1;
              st <= S_WFILL;
            end else begin
              rsp_valid <= 1'b1;
              rsp_err <= 1'b0;
              rsp_data <= mem_rdata;
              rsp_tag <= r_tag;
              req_ready <= 1'b1;
              st <= S_IDLE;
            end
          end
        end
        S_WFILL: begin
          if (mem_valid && mem_ready) begin
            mem_valid <= 1'b1;
            mem_we <= 1'b1;
            mem_meta <= 1'b1;
            mem_page <= r_page;
            mem_line <= '0;
            mem_wdata <= closed_meta;
            mem_be <= '1;
            st <= S_WLAST;
          end
        end
        S_WLAST: begin
          if (mem_valid && mem_ready) begin
            rsp_valid <= 1'b1;
            rsp_err <= 1'b0;
            rsp_data <= '0;
            rsp_tag <= r_tag;
            req_ready <= 1'b1;
            st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hole_redirect_chk.sv
module hole_redirect_chk #(
  parameter int DATA_W = 64,
  localparam int BE_W = DATA_W / 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic [DATA_W-1:0] rsp_data,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_we,
  input logic              mem_meta,
  input logic [BE_W-1:0]   mem_be
);
  a_r1_idle_no_mem: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !mem_valid);

  a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  a_r8_rsp_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  a_r5_err_data_zero: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_err) |-> (rsp_data == '0));

  a_r7_meta_write_full: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && mem_we && mem_meta) |-> (&mem_be));

  a_r2_mem_req_held: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> mem_valid);
endmodule

bind hole_redirect hole_redirect_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
  .mem_meta(mem_meta), .mem_be(mem_be));

// File: tb/hole_redirect_tb_top.sv
`timescale 1ns/1ps
module hole_redirect_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        req_valid = 1'b0, req_we = 1'b0;
  logic        req_ready;
  logic [15:0] req_page = '0;
  logic [3:0]  req_line = '0, req_tag = '0;
  logic [63:0] req_wdata = '0;
  logic [7:0]  req_be = '0;
  logic        rsp_valid, rsp_err;
  logic [3:0]  rsp_tag;
  logic [63:0] rsp_data;
  logic        mem_valid, mem_we, mem_meta;
  logic        mem_ready = 1'b1;
  logic [15:0] mem_page;
  logic [3:0]  mem_line;
  logic [63:0] mem_wdata;
  logic [7:0]  mem_be;
  logic        mem_rvalid = 1'b0;
  logic [63:0] mem_rdata = '0;

  hole_redirect dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_page(req_page), .req_line(req_line),
    .req_wdata(req_wdata), .req_be(req_be), .req_tag(req_tag),
    .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_data(rsp_data),
    .rsp_err(rsp_err), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_we(mem_we), .mem_meta(mem_meta), .mem_page(mem_page),
    .mem_line(mem_line), .mem_wdata(mem_wdata), .mem_be(mem_be),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata));

  // memory model: 64 pages of 16 lines plus one metadata line per page
  logic [63:0] dmem [0:1023];
  logic [63:0] mmem [0:63];
  int meta_rd = 0, data_rd = 0, wr_cnt = 0, meta_wr = 0;

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (mem_valid && mem_ready) begin
      if (mem_we) begin
        wr_cnt <= wr_cnt + 1;
        if (mem_meta) begin
          meta_wr <= meta_wr + 1;
          for (int k = 0; k < 8; k++)
            if (mem_be[k]) mmem[mem_page[5:0]][k*8 +: 8] <= mem_wdata[k*8 +: 8];
        end else begin
          for (int k = 0; k < 8; k++)
            if (mem_be[k]) dmem[{mem_page[5:0], mem_line}][k*8 +: 8] <= mem_wdata[k*8 +: 8];
        end
      end else begin
        mem_rvalid <= 1'b1;
        if (mem_meta) begin
          meta_rd <= meta_rd + 1;
          mem_rdata <= mmem[mem_page[5:0]];
        end else begin
          data_rd <= data_rd + 1;
          mem_rdata <= dmem[{mem_page[5:0], mem_line}];
        end
      end
    end
  end

  int errors = 0, checks = 0;
  logic [63:0] got_data;
  logic        got_err, got_rsp;
  logic [3:0]  got_tag;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] pat(input int p, input int l);
    return {16'hBEEF, 16'(p), 16'(l), 16'h5A5A};
  endfunction

  // slot i: [4i+2:4i] minor (0 hole, 1 closed, 2 present), [4i+3] pointer bit i
  function automatic logic [63:0] mk_meta(input logic [15:0] ptr, input logic [15:0] holes,
                                          input logic [15:0] ones);
    logic [63:0] m;
    for (int i = 0; i < 16; i++) begin
      m[i*4 +: 3] = holes[i] ? 3'd0 : (ones[i] ? 3'd1 : 3'd2);
      m[i*4 + 3]  = ptr[i];
    end
    return m;
  endfunction

  task automatic do_req(input logic we, input int page, input int line,
                        input logic [63:0] wd, input logic [7:0] be, input logic [3:0] tag,
                        input bit chk_busy);
    @(negedge clk);
    meta_rd = 0; data_rd = 0; wr_cnt = 0; meta_wr = 0;
    req_valid = 1'b1; req_we = we; req_page = 16'(page); req_line = 4'(line);
    req_wdata = wd; req_be = be; req_tag = tag;
    @(negedge clk);
    req_valid = 1'b0;
    if (chk_busy) check("R8 ready low while busy", 64'(req_ready), 64'd0);
    got_rsp = 1'b0;
    for (int c = 0; c < 400 && !got_rsp; c++) begin
      if (rsp_valid) begin
        got_rsp = 1'b1; got_data = rsp_data; got_err = rsp_err; got_tag = rsp_tag;
      end else @(negedge clk);
    end
    check("R8 response arrived", 64'(got_rsp), 64'd1);
    check("R8 tag echoed", 64'(got_tag), 64'(tag));
    @(negedge clk);
    check("R8 rsp one cycle", 64'(rsp_valid), 64'd0);
    check("R8 ready restored", 64'(req_ready), 64'd1);
  endtask

  task automatic t_reset;
    check("R1 ready after reset", 64'(req_ready), 64'd1);
    check("R1 rsp_valid low", 64'(rsp_valid), 64'd0);
    check("R1 mem_valid low", 64'(mem_valid), 64'd0);
  endtask

  task automatic t_read_present;
    do_req(1'b0, 1, 3, '0, '0, 4'h3, 1'b1);
    check("R2 data", got_data, pat(1, 3));
    check("R2 err", 64'(got_err), 64'd0);
    check("R2 meta reads", 64'(meta_rd), 64'd1);
    check("R2 data reads", 64'(data_rd), 64'd1);
  endtask

  task automatic t_read_hole;
    do_req(1'b0, 2, 7, '0, '0, 4'h5, 1'b0);
    check("R3 redirected data", got_data, pat(1, 7));
    check("R3 meta reads", 64'(meta_rd), 64'd2);
    do_req(1'b0, 2, 4, '0, '0, 4'h6, 1'b0);
    check("R3 present line of linked page", got_data, pat(2, 4));
    check("R3 present meta reads", 64'(meta_rd), 64'd1);
  endtask

  task automatic t_chain;
    do_req(1'b0, 3, 9, '0, '0, 4'h7, 1'b0);
    check("R4 two-hop data", got_data, pat(1, 9));
    check("R4 meta reads", 64'(meta_rd), 64'd3);
    check("R4 data reads", 64'(data_rd), 64'd1);
  endtask

  task automatic t_limit;
    do_req(1'b0, 21, 5, '0, '0, 4'h8, 1'b0);
    check("R5 eight hops ok", got_data, pat(29, 5));
    check("R5 eight hops err", 64'(got_err), 64'd0);
    check("R5 eight hops meta reads", 64'(meta_rd), 64'd9);
    do_req(1'b0, 20, 5, '0, '0, 4'h9, 1'b0);
    check("R5 nine hops err", 64'(got_err), 64'd1);
    check("R5 nine hops data", got_data, 64'd0);
    check("R5 nine hops no data read", 64'(data_rd), 64'd0);
    do_req(1'b0, 30, 0, '0, '0, 4'hA, 1'b0);
    check("R5 loop err", 64'(got_err), 64'd1);
    do_req(1'b1, 20, 5, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, 4'hB, 1'b0);
    check("R5 write err", 64'(got_err), 64'd1);
    check("R5 write no mem write", 64'(wr_cnt), 64'd0);
    check("R5 write dest untouched", dmem[{6'd20, 4'd5}], pat(20, 5));
  endtask

  task automatic t_write_present;
    do_req(1'b1, 1, 0, 64'hA5A5_A5A5_A5A5_A5A5, 8'h0F, 4'hC, 1'b0);
    check("R6 merged by be", dmem[{6'd1, 4'd0}], {pat(1, 0)[63:32], 32'hA5A5_A5A5});
    check("R6 single write", 64'(wr_cnt), 64'd1);
    check("R6 no meta write", 64'(meta_wr), 64'd0);
    check("R6 err", 64'(got_err), 64'd0);
  endtask

  task automatic t_write_hole;
    do_req(1'b1, 4, 2, 64'h1111_2222_3333_4444, 8'hF0, 4'hD, 1'b0);
    check("R7 dest merged", dmem[{6'd4, 4'd2}], {32'h1111_2222, pat(1, 2)[31:0]});
    check("R7 meta closed", mmem[4], mk_meta(16'h0001, 16'h0040, 16'h0004));
    check("R7 source untouched", dmem[{6'd1, 4'd2}], pat(1, 2));
    check("R7 writes", 64'(wr_cnt), 64'd2);
    do_req(1'b0, 4, 2, '0, '0, 4'hE, 1'b0);
    check("R7 read after close", got_data, {32'h1111_2222, pat(1, 2)[31:0]});
    check("R7 no redirect after close", 64'(meta_rd), 64'd1);
    do_req(1'b0, 4, 6, '0, '0, 4'hF, 1'b0);
    check("R7 other hole still redirects", got_data, pat(1, 6));
  endtask

  bit done = 0;
  initial begin
    for (int p = 0; p < 64; p++) begin
      mmem[p] = mk_meta(16'h0000, 16'h0000, 16'h0000);
      for (int l = 0; l < 16; l++) dmem[p*16 + l] = pat(p, l);
    end
    mmem[2] = mk_meta(16'd1, 16'h0280, 16'h0000);   // holes at 7,9 -> page 1
    mmem[3] = mk_meta(16'd2, 16'h0200, 16'h0000);   // hole at 9 -> page 2
    mmem[4] = mk_meta(16'd1, 16'h0044, 16'h0000);   // holes at 2,6 -> page 1
    for (int p = 20; p < 29; p++) mmem[p] = mk_meta(16'(p + 1), 16'h0020, 16'h0000);
    mmem[30] = mk_meta(16'd30, 16'h0001, 16'h0000); // self-loop at line 0
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_read_present();
    t_read_hole();
    t_chain();
    t_limit();
    t_write_present();
    t_write_hole();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule